// File: doc/BRIEF.md
# Serial Ethernet Receive Synchronizer and Address Filter

This block sits between a serial receive path and the frame buffer of an Ethernet MAC. It takes one bit per clock while the data-valid input is high, locks onto the preamble, aligns to byte boundaries when it sees the start-of-frame delimiter, and checks the bit pattern for bad preamble pairs. Once it is aligned, it builds bytes from the stream, least significant bit first. It then tests the six-byte destination address against a programmed station address and a multicast enable. It also keeps a running CRC-32 over the whole frame.

Frames that pass the address test are delivered as a byte stream with the frame check sequence left in place. A start flag marks the first byte. After the line goes quiet, a separate end strobe carries the CRC verdict and an alignment-error flag. Frames that fail the address test, frames aborted in the preamble and frames shorter than a full destination address produce no output at all. Once a burst is dropped, the rest of that burst is ignored.

Top module: `eth_rx_filter`

## Requirements
- R1: After reset, out_valid, out_sof, out_eof, out_crc_ok and out_align_err are all low.
- R2: Byte alignment starts right after the last eight received bits, oldest first, read 1,0,1,0,1,0,1,1. The bits that follow are grouped into bytes, with the first received bit as bit 0. This holds even when no preamble bits come before those eight.
- R3: If a received bit at index 8 or later of a burst (counting from 0) equals the bit before it, and it does not complete the delimiter, the burst is aborted and nothing from it is delivered.
- R4: Equal adjacent bits at bit indices 0 to 7 of a burst do not abort reception.
- R5: When bit 0 of the first address byte is 0, the frame is delivered only if all six address bytes equal node_addr. Byte k of the address is compared with node_addr[8k+7:8k].
- R6: When bit 0 of the first address byte is 1 (multicast, which includes the all-ones broadcast address), the frame is delivered if and only if mcast_en is high.
- R7: A delivered frame appears on out_data with out_valid, in received order, from the first address byte to the last FCS byte. out_sof is high only with the first byte.
- R8: An end strobe on out_eof follows the last byte of each delivered frame, after rx_dv falls. out_crc_ok is high on that strobe exactly when the CRC-32 over all received bits, FCS included, leaves the good residue. That residue is 0xC704DD7B in normal bit order, and 0xDEBB20E3 in the reflected shift register.
- R9: out_align_err is high on the end strobe when the number of bits after the delimiter is not a multiple of eight. The full bytes before the leftover bits are still delivered.
- R10: After an abort or a rejected address, every bit is ignored until rx_dv goes low, even a valid delimiter and frame later in the same burst. The next burst is received normally.
- R11: A burst that ends before six address bytes are complete produces no output.
- R12: out_eof never coincides with out_valid, and out_crc_ok and out_align_err are high only together with out_eof.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit per cycle while rx_dv is high |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Serial receive data |
| rx_dv | input | 1 | Receive data valid; its falling edge ends a burst |
| node_addr | input | 48 | Station address; bits [7:0] are the first address byte |
| mcast_en | input | 1 | Accept multicast and broadcast destinations |
| out_valid | output | 1 | out_data carries a frame byte |
| out_data | output | 8 | Delivered frame byte |
| out_sof | output | 1 | First byte of a delivered frame |
| out_eof | output | 1 | End-of-frame strobe carrying the status flags |
| out_crc_ok | output | 1 | CRC residue correct, valid with out_eof |
| out_align_err | output | 1 | Frame ended off a byte boundary, valid with out_eof |

## Verification
Several kinds of burst are sent through the block:
- Clean preambles of different lengths, including none at all, show that alignment comes only from the delimiter window.
- Bursts with an equal pair early in the preamble, and bursts with an equal pair late in it, separate the tolerated start-up region from the abort region.
- Destinations that match, differ in one byte, are multicast with the enable on or off, or are broadcast, exercise each branch of the filter.
- Frames with a flipped payload bit, trailing odd bits or too few address bytes separate the CRC, alignment and short-frame outcomes from a good frame.
- A rejected or aborted header is followed by a valid frame in the same burst, which shows that the block waits for the line to go idle.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_DATA = 2'd2,
        ST_DROP = 2'd3
    } rx_state_e;

    // Last eight bits, oldest in bit 7, that mark the byte boundary.
    localparam logic [7:0]  SFD_WINDOW     = 8'hAB;
    // Bits at the start of a burst where equal neighbours are tolerated.
    localparam int          PRE_GUARD_BITS = 8;
    // Reflected CRC-32 polynomial and the residue of a good frame.
    localparam logic [31:0] CRC_POLY_R     = 32'hEDB88320;
    localparam logic [31:0] CRC_GOOD_R     = 32'hDEBB20E3;
    localparam logic [31:0] CRC_SEED       = 32'hFFFFFFFF;

endpackage

// File: rtl/eth_rx_crc_bit.sv
module eth_rx_crc_bit
    import eth_rx_pkg::*;
(
    input  logic [31:0] crc_in,
    input  logic        din,
    output logic [31:0] crc_out
);
    logic fb;

    // One step of the LSB-first CRC-32 shift register.
    assign fb      = crc_in[0] ^ din;
    assign crc_out = {1'b0, crc_in[31:1]} ^ (fb ? CRC_POLY_R : 32'h0);
endmodule

// File: rtl/eth_rx_addr_match.sv
module eth_rx_addr_match #(
    parameter int ADDR_BYTES = 6
) (
    input  logic [8*ADDR_BYTES-1:0] dest,
    input  logic [8*ADDR_BYTES-1:0] station,
    input  logic                    mcast_en,
    output logic                    accept
);
    logic group_bit;

    // The first bit on the wire is bit 0 of the first byte.
    assign group_bit = dest[0];
    assign accept    = group_bit ? mcast_en : (dest == station);
endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
    import eth_rx_pkg::*;
#(
    parameter int ADDR_BYTES = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_bit,
    input  logic                    rx_dv,
    input  logic [8*ADDR_BYTES-1:0] node_addr,
    input  logic                    mcast_en,
    output logic                    out_valid,
    output logic [7:0]              out_data,
    output logic                    out_sof,
    output logic                    out_eof,
    output logic                    out_crc_ok,
    output logic                    out_align_err
);
    localparam int DAW  = 8 * ADDR_BYTES;
    localparam int CNTW = $clog2(ADDR_BYTES + 1);

    typedef struct packed {
        rx_state_e       state;
        logic [7:0]      win;       // recent preamble bits, newest in bit 0
        logic [3:0]      pre_cnt;   // bits seen in the burst, saturating
        logic [2:0]      bit_cnt;   // position inside the current byte
        logic [CNTW-1:0] byte_cnt;  // address bytes assembled
        logic [7:0]      sh;        // byte under assembly
        logic [DAW-1:0]  da;        // destination address, later replayed
        logic [31:0]     crc;
        logic            acc;       // frame accepted
        logic [CNTW-1:0] drain;     // address bytes left to replay
        logic            first;     // next replayed byte starts the frame
        logic            end_pend;
        logic            end_crc;
        logic            end_align;
        logic            o_valid;
        logic [7:0]      o_data;
        logic            o_sof;
        logic            o_eof;
        logic            o_crc;
        logic            o_align;
    } regs_t;

    regs_t r_q, r_d;

    logic [7:0]     byte_next;
    logic [DAW-1:0] da_cand;
    logic [31:0]    crc_step;
    logic           addr_ok;
    logic [7:0]     win_next;

    assign byte_next = {rx_bit, r_q.sh[7:1]};
    assign da_cand   = {byte_next, r_q.da[DAW-1:8]};
    assign win_next  = {r_q.win[6:0], rx_bit};

    eth_rx_crc_bit u_crc (
        .crc_in  (r_q.crc),
        .din     (rx_bit),
        .crc_out (crc_step)
    );

    eth_rx_addr_match #(.ADDR_BYTES(ADDR_BYTES)) u_match (
        .dest     (da_cand),
        .station  (node_addr),
        .mcast_en (mcast_en),
        .accept   (addr_ok)
    );

    always_comb begin
        r_d         = r_q;
        r_d.o_valid = 1'b0;
        r_d.o_sof   = 1'b0;
        r_d.o_eof   = 1'b0;
        r_d.o_crc   = 1'b0;
        r_d.o_align = 1'b0;

        // Output side: replay held address bytes, then the end strobe.
        if (r_q.drain != '0) begin
            r_d.o_valid = 1'b1;
            r_d.o_data  = r_q.da[7:0];
            r_d.o_sof   = r_q.first;
            r_d.first   = 1'b0;
            r_d.da      = r_q.da >> 8;
            r_d.drain   = r_q.drain - 1'b1;
        end else if (r_q.end_pend) begin
            r_d.o_eof    = 1'b1;
            r_d.o_crc    = r_q.end_crc;
            r_d.o_align  = r_q.end_align;
            r_d.end_pend = 1'b0;
        end

        unique case (r_q.state)
            ST_IDLE: begin
                if (rx_dv) begin
                    r_d.win     = {7'd0, rx_bit};
                    r_d.pre_cnt = 4'd1;
                    r_d.state   = ST_PRE;
                end
            end
            ST_PRE: begin
                if (!rx_dv) begin
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.win = win_next;
                    if (r_q.pre_cnt >= 4'd7 && win_next == SFD_WINDOW) begin
                        r_d.state    = ST_DATA;
                        r_d.bit_cnt  = '0;
                        r_d.byte_cnt = '0;
                        r_d.crc      = CRC_SEED;
                        r_d.acc      = 1'b0;
                        r_d.first    = 1'b1;
                    end else if (r_q.pre_cnt >= 4'(PRE_GUARD_BITS)
                                 && rx_bit == r_q.win[0]) begin
                        r_d.state = ST_DROP;
                    end else if (r_q.pre_cnt < 4'(PRE_GUARD_BITS)) begin
                        r_d.pre_cnt = r_q.pre_cnt + 4'd1;
                    end
                end
            end
            ST_DATA: begin
                if (!rx_dv) begin
                    r_d.state = ST_IDLE;
                    if (r_q.acc) begin
                        r_d.end_pend  = 1'b1;
                        r_d.end_crc   = (r_q.crc == CRC_GOOD_R);
                        r_d.end_align = (r_q.bit_cnt != 3'd0);
                    end
                end else begin
                    r_d.sh      = byte_next;
                    r_d.crc     = crc_step;
                    r_d.bit_cnt = r_q.bit_cnt + 3'd1;
                    if (r_q.bit_cnt == 3'd7) begin
                        if (r_q.byte_cnt < CNTW'(ADDR_BYTES)) begin
                            r_d.da       = da_cand;
                            r_d.byte_cnt = r_q.byte_cnt + 1'b1;
                            if (r_q.byte_cnt == CNTW'(ADDR_BYTES - 1)) begin
                                if (addr_ok) begin
                                    r_d.acc   = 1'b1;
                                    r_d.drain = CNTW'(ADDR_BYTES);
                                end else begin
                                    r_d.state = ST_DROP;
                                end
                            end
                        end else if (r_q.acc) begin
                            r_d.o_valid = 1'b1;
                            r_d.o_data  = byte_next;
                        end
                    end
                end
            end
            ST_DROP: begin
                if (!rx_dv) begin
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid     = r_q.o_valid;
    assign out_data      = r_q.o_data;
    assign out_sof       = r_q.o_sof;
    assign out_eof       = r_q.o_eof;
    assign out_crc_ok    = r_q.o_crc;
    assign out_align_err = r_q.o_align;
endmodule

// File: rtl/eth_rx_filter_chk.sv
module eth_rx_filter_chk (
    input logic clk,
    input logic rst_n,
    input logic out_valid,
    input logic out_sof,
    input logic out_eof,
    input logic out_crc_ok,
    input logic out_align_err
);
    logic open_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else if (out_eof) begin
            open_q <= 1'b0;
        end else if (out_valid && out_sof) begin
            open_q <= 1'b1;
        end
    end

    a_r12_sof_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    a_r12_eof_alone: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> !out_valid);

    a_r12_status_only_at_eof: assert property (@(posedge clk) disable iff (!rst_n)
        (out_crc_ok || out_align_err) |-> out_eof);

    a_r7_bytes_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sof) |-> open_q);

    a_r8_eof_closes_open_frame: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> open_q);

    a_r7_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> !open_q);
endmodule

bind eth_rx_filter eth_rx_filter_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .out_valid     (out_valid),
    .out_sof       (out_sof),
    .out_eof       (out_eof),
    .out_crc_ok    (out_crc_ok),
    .out_align_err (out_align_err)
);

// File: tb/eth_rx_filter_tb_top.sv
module eth_rx_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_bit = 1'b0;
    logic        rx_dv = 1'b0;
    logic [47:0] node_addr = 48'h665544332210;
    logic        mcast_en = 1'b0;
    logic        out_valid, out_sof, out_eof, out_crc_ok, out_align_err;
    logic [7:0]  out_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        bit         is_eof;
        logic [7:0] data;
        bit         sof;
        bit         crc_ok;
        bit         crc_dc;
        bit         align;
        string      req;
    } exp_t;

    exp_t       exp_q[$];
    bit         bits_q[$];
    logic [7:0] fr[$];

    always #5 clk = ~clk;

    eth_rx_filter dut_i (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_dv(rx_dv),
        .node_addr(node_addr), .mcast_en(mcast_en),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .out_crc_ok(out_crc_ok), .out_align_err(out_align_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: compares delivered items against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done && (out_valid || out_eof)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10/R11", "unexpected output", {23'd0, out_eof, out_data}, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.is_eof) begin
                    check(out_eof && !out_valid, e.req, "end strobe", {31'd0, out_eof}, 32'h1);
                    if (!e.crc_dc)
                        check(out_crc_ok == e.crc_ok, e.req, "crc_ok", {31'd0, out_crc_ok}, {31'd0, e.crc_ok});
                    check(out_align_err == e.align, e.req, "align_err", {31'd0, out_align_err}, {31'd0, e.align});
                end else begin
                    check(out_valid && out_data == e.data, e.req, "byte", {24'd0, out_data}, {24'd0, e.data});
                    check(out_sof == e.sof, e.req, "sof", {31'd0, out_sof}, {31'd0, e.sof});
                end
            end
        end
    end

    function automatic logic [31:0] crc_of(input logic [7:0] b[$]);
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (b[i]) begin
            for (int k = 0; k < 8; k++) begin
                bit fb = c[0] ^ b[i][k];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c;
    endfunction

    // Builds a frame: destination, source, type, payload, then FCS.
    task automatic make_frame(input logic [47:0] da, input int plen, input int seed);
        logic [31:0] fcs;
        fr.delete();
        for (int i = 0; i < 6; i++) fr.push_back(da[8*i +: 8]);
        for (int i = 0; i < 6; i++) fr.push_back(8'(8'hA0 + i));
        fr.push_back(8'h08); fr.push_back(8'h00);
        for (int i = 0; i < plen; i++) fr.push_back(8'(seed * 7 + i * 13));
        fcs = ~crc_of(fr);
        for (int i = 0; i < 4; i++) fr.push_back(fcs[8*i +: 8]);
    endtask

    task automatic add_pre(input int n);
        for (int i = 0; i < n; i++) bits_q.push_back((i % 2) == 0);
    endtask

    task automatic add_sfd();
        logic [7:0] w = 8'hAB;
        for (int i = 7; i >= 0; i--) bits_q.push_back(w[i]);
    endtask

    task automatic add_frame_bits();
        foreach (fr[i]) for (int k = 0; k < 8; k++) bits_q.push_back(fr[i][k]);
    endtask

    task automatic expect_frame(input bit crc_ok, input bit dc, input bit align, input string req);
        foreach (fr[i]) exp_q.push_back('{0, fr[i], (i == 0), 0, 0, 0, req});
        exp_q.push_back('{1, 8'h00, 0, crc_ok, dc, align, req});
    endtask

    task automatic drive_burst();
        foreach (bits_q[i]) begin
            @(negedge clk);
            rx_dv  = 1'b1;
            rx_bit = bits_q[i];
        end
        @(negedge clk);
        rx_dv  = 1'b0;
        rx_bit = 1'b0;
        bits_q.delete();
        repeat (16) @(negedge clk);
    endtask

    task automatic expect_drained(input string req);
        check(exp_q.size() == 0, req, "scoreboard drained", exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "R1", "watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset values
        check({out_valid, out_sof, out_eof, out_crc_ok, out_align_err} == 5'b0,
              "R1", "outputs in reset", {27'd0, out_valid, out_sof, out_eof, out_crc_ok, out_align_err}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({out_valid, out_eof} == 2'b0, "R1", "idle after reset", {30'd0, out_valid, out_eof}, 0);

        // R2 R5 R7 R8: good unicast, full preamble
        make_frame(node_addr, 12, 1);
        add_pre(56); add_sfd(); add_frame_bits();
        expect_frame(1, 0, 0, "R7/R8 unicast");
        drive_burst(); expect_drained("R7");

        // R2: no preamble before the delimiter window
        make_frame(node_addr, 3, 2);
        add_sfd(); add_frame_bits();
        expect_frame(1, 0, 0, "R2 bare delimiter");
        drive_burst(); expect_drained("R2");

        // R5: one address byte differs
        make_frame(node_addr ^ 48'h000100000000, 8, 3);
        add_pre(20); add_sfd(); add_frame_bits();
        drive_burst(); expect_drained("R5 mismatch");

        // R6: multicast with enable low, then high, then broadcast
        make_frame(48'h0000005E0001, 6, 4);
        add_pre(20); add_sfd(); add_frame_bits();
        drive_burst(); expect_drained("R6 mcast off");
        mcast_en = 1'b1;
        make_frame(48'h0000005E0001, 6, 5);
        add_pre(20); add_sfd(); add_frame_bits();
        expect_frame(1, 0, 0, "R6 mcast on");
        drive_burst(); expect_drained("R6");
        make_frame(48'hFFFFFFFFFFFF, 4, 6);
        add_pre(20); add_sfd(); add_frame_bits();
        expect_frame(1, 0, 0, "R6 broadcast");
        drive_burst(); expect_drained("R6");
        mcast_en = 1'b0;

        // R8: corrupted payload bit gives crc_ok low
        make_frame(node_addr, 10, 7);
        fr[16] = fr[16] ^ 8'h04;
        add_pre(30); add_sfd(); add_frame_bits();
        expect_frame(0, 0, 0, "R8 bad crc");
        drive_burst(); expect_drained("R8");

        // R9: three trailing bits
        make_frame(node_addr, 5, 8);
        add_pre(30); add_sfd(); add_frame_bits();
        bits_q.push_back(1); bits_q.push_back(0); bits_q.push_back(1);
        expect_frame(0, 1, 1, "R9 align");
        drive_burst(); expect_drained("R9");

        // R4: equal pair at indices 0 and 1 tolerated
        make_frame(node_addr, 4, 9);
        bits_q.push_back(0); bits_q.push_back(0);
        add_pre(14); add_sfd(); add_frame_bits();
        expect_frame(1, 0, 0, "R4 early pair");
        drive_burst(); expect_drained("R4");

        // R3 R10: equal pair at index 10, valid frame later in same burst ignored
        make_frame(node_addr, 4, 10);
        add_pre(10); bits_q.push_back(0);
        add_pre(20); add_sfd(); add_frame_bits();
        drive_burst(); expect_drained("R3 abort");

        // R10: recovery on next burst
        make_frame(node_addr, 6, 11);
        add_pre(16); add_sfd(); add_frame_bits();
        expect_frame(1, 0, 0, "R10 recovery");
        drive_burst(); expect_drained("R10");

        // R10: rejected address, then valid frame in same burst ignored
        make_frame(48'h0A0B0C0D0E00, 4, 12);
        add_pre(16); add_sfd(); add_frame_bits();
        make_frame(node_addr, 4, 13);
        add_pre(16); add_sfd(); add_frame_bits();
        drive_burst(); expect_drained("R10 reject");

        // R11: burst ends after four address bytes
        make_frame(node_addr, 4, 14);
        add_pre(16); add_sfd();
        for (int i = 0; i < 4; i++) for (int k = 0; k < 8; k++) bits_q.push_back(fr[i][k]);
        drive_burst(); expect_drained("R11 short");

        // R7: minimum-length body right after another frame
        make_frame(node_addr, 0, 15);
        add_pre(8); add_sfd(); add_frame_bits();
        expect_frame(1, 0, 0, "R7 short body");
        drive_burst(); expect_drained("R7");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule